// File: doc/BRIEF.md
# I2C Register Target with Shared Address Counter

This block is an I2C target that holds a small bank of byte-wide registers. It has two registers by default. It oversamples SCL and SDA on the system clock and drives SDA only through an open-drain pull-down enable. A host writes to it with the target address, a register index byte and then data bytes. It reads either by addressing the target for read straight away, which continues from the internal counter, or by a dummy write of the register index followed by a repeated START and a read.

A single address counter serves both directions. It advances after every data byte, whether the byte is sent or received, and it wraps from the last register back to register 0. A bare read therefore resumes one past the last register touched. The register contents are also presented in parallel for the logic that consumes them.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) is recognised in any state. A START discards any partly shifted byte and restarts address reception, and it leaves the address counter unchanged. A STOP returns the target to idle with SDA released.
- R2: When the first byte after START carries the 7-bit target address `DEV_ADDR` in bits 7..1, the target acknowledges by pulling SDA low for the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: On an address mismatch the target leaves SDA released for the acknowledge and for all later bits. It changes neither registers nor counter until the next START or STOP.
- R4: In a write, the first byte after the address loads the counter from its low log2(NUM_REGS) bits. Each following byte is stored at the counter address. Every byte is acknowledged.
- R5: The counter increments by one after every data byte that is written or read, and it wraps from NUM_REGS-1 to 0.
- R6: In a read, the target acknowledges its address and then sends the register at the counter address, MSB first.
- R7: If the host acknowledges a read byte, the target sends the next register. If the host does not acknowledge it, the target keeps SDA released until the next START or STOP.
- R8: A read without a register index returns the register one past the last one read or written, modulo NUM_REGS.
- R9: A write of a register index followed by a repeated START and a read returns data starting at that index.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset all registers are 0, the counter is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_q_o | output | 8*NUM_REGS | Register contents, register k in bits 8k+7..8k |

## Verification
The bench targets the wrap of the shared counter in both directions. A design that wrapped only on writes, or that kept separate read and write pointers, would return the wrong byte on the first bare read after a write burst. A START dropped into the middle of a register-index byte checks that half-shifted bits are discarded and the counter is left alone; a design that got this wrong would read from a corrupted index. After a host NACK the host clocks out a further byte, and any pull-down from a target that kept transmitting shows up as a byte other than FFh. A sweep over all 127 foreign addresses checks that the target never acknowledges and that nothing lands in the registers.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK,
    S_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int NUM_REGS = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic [7:0]            rdata_o,
  output logic [8*NUM_REGS-1:0] regs_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs_q[g] <= 8'h00;
      else if (we_i && waddr_i == AW'(g))    regs_q[g] <= wdata_i;
    end
    assign regs_o[8*g +: 8] = regs_q[g];
  end

  assign rdata_o = regs_q[raddr_i];

  // R4: a write strobe lands its byte at the addressed register
  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 2,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] reg_q_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  tgt_state_e state_q;
  logic [7:0]    rx_q, tx_q, rd_data;
  logic [2:0]    bit_cnt_q;
  logic          byte_done_q, rw_q, first_wr_q, host_ack_q, oe_q;
  logic [AW-1:0] cnt_q, cnt_inc;
  logic          wr_en;

  assign cnt_inc = cnt_q + 1'b1;
  assign wr_en   = (state_q == S_RX) && scl_fall && byte_done_q && !first_wr_q;

  i2c_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(cnt_q), .wdata_i(rx_q),
    .raddr_i(cnt_q), .rdata_o(rd_data), .regs_o(reg_q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      rx_q        <= '0;
      tx_q        <= '0;
      bit_cnt_q   <= '0;
      byte_done_q <= 1'b0;
      rw_q        <= 1'b0;
      first_wr_q  <= 1'b1;
      host_ack_q  <= 1'b0;
      oe_q        <= 1'b0;
      cnt_q       <= '0;
    end else if (start) begin
      state_q     <= S_ADDR;
      bit_cnt_q   <= '0;
      byte_done_q <= 1'b0;
      first_wr_q  <= 1'b1;
      oe_q        <= 1'b0;
    end else if (stop) begin
      state_q     <= S_IDLE;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_RX: begin
          if (scl_rise) begin
            rx_q      <= {rx_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == 3'd7) byte_done_q <= 1'b1;
          end else if (scl_fall && byte_done_q) begin
            byte_done_q <= 1'b0;
            if (state_q == S_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= rx_q[0];
                state_q <= S_ADDR_ACK;
              end else begin
                state_q <= S_SKIP;
              end
            end else begin
              oe_q    <= 1'b1;
              state_q <= S_RX_ACK;
              if (first_wr_q) begin
                cnt_q      <= rx_q[AW-1:0];
                first_wr_q <= 1'b0;
              end else begin
                cnt_q <= cnt_inc;
              end
            end
          end
        end
        S_ADDR_ACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= rd_data;
            oe_q    <= ~rd_data[7];
            state_q <= S_TX;
          end else begin
            oe_q    <= 1'b0;
            state_q <= S_RX;
          end
        end
        S_RX_ACK: if (scl_fall) begin
          oe_q    <= 1'b0;
          state_q <= S_RX;
        end
        S_TX: if (scl_fall) begin
          if (bit_cnt_q == 3'd7) begin
            oe_q    <= 1'b0;
            cnt_q   <= cnt_inc;
            state_q <= S_TX_ACK;
          end else begin
            tx_q      <= {tx_q[6:0], 1'b0};
            oe_q      <= ~tx_q[6];
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        S_TX_ACK: begin
          if (scl_rise) host_ack_q <= ~sda_s;
          else if (scl_fall) begin
            if (host_ack_q) begin
              tx_q      <= rd_data;
              oe_q      <= ~rd_data[7];
              bit_cnt_q <= '0;
              state_q   <= S_TX;
            end else begin
              state_q <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R10: drive is frozen across an SCL high phase
  a_r10_oe_quiet_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && !scl_rise) |-> ($stable(sda_oe_o) || start || stop));
  // R3: a target that has dropped out never pulls SDA
  a_r3_skip_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SKIP) |-> !sda_oe_o);
  // R1: START rearms address reception, counter kept
  a_r1_start_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == S_ADDR && bit_cnt_q == 3'd0 && cnt_q == $past(cnt_q)));
  // R1: STOP returns to idle with SDA released
  a_r1_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state_q == S_IDLE && !sda_oe_o));
  // R5: counter advances once a read byte has been shifted out
  a_r5_tx_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TX && scl_fall && bit_cnt_q == 3'd7) |=> cnt_q == $past(cnt_inc));
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 6;
  localparam logic [6:0] DEV        = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic oe;
  logic [15:0] regq;
  wire  sda;

  assign sda = ~(m_low | oe);

  i2c_reg_target #(.DEV_ADDR(DEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe_o(oe), .reg_q_o(regq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  logic [7:0] mreg [2];
  int mcnt = 0;
  logic scl_p = 1'b1;
  logic oe_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n && scl && scl_p && oe !== oe_p) r10_viol++;
    scl_p = scl;
    oe_p  = oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    m_low = 1'b1; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic do_stop();
    m_low = 1'b1; wq();
    scl = 1'b1;   wq();
    m_low = 1'b0; wq();
  endtask

  task automatic wbit(input logic b);
    m_low = ~b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    b = sda;      wq();
    scl = 1'b0;   wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~mack);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    mreg[0] = 8'h00; mreg[1] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R11 oe", oe, 0);
    chk("R11 regs", regq, 16'h0000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // burst write with wrap
    do_start();
    wbyte({DEV, 1'b0}, ack); chk("R2 addr ack", ack, 1);
    wbyte(8'h00, ack);       chk("R4 index ack", ack, 1);
    wbyte(8'h3C, ack);       chk("R4 data ack", ack, 1);
    wbyte(8'hA5, ack);
    wbyte(8'h81, ack);       chk("R5 wrap ack", ack, 1);
    do_stop();
    mreg[0] = 8'h81; mreg[1] = 8'hA5; mcnt = 1;
    chk("R5 wrap write reg0", regq[7:0], 8'h81);
    chk("R4 reg1", regq[15:8], 8'hA5);

    // bare read continues after last write
    do_start();
    wbyte({DEV, 1'b1}, ack); chk("R6 read addr ack", ack, 1);
    rbyte(d, 1'b1);          chk("R8 current read", d, mreg[mcnt]);
    mcnt = (mcnt + 1) % 2;
    rbyte(d, 1'b0);          chk("R5 read wrap", d, mreg[mcnt]);
    mcnt = (mcnt + 1) % 2;
    do_stop();
    chk("R1 stop releases", oe, 0);

    // NACK then host keeps clocking: line must stay high
    do_start();
    wbyte({DEV, 1'b1}, ack);
    rbyte(d, 1'b0);          chk("R6 read data", d, mreg[mcnt]);
    mcnt = (mcnt + 1) % 2;
    rbyte(d, 1'b1);          chk("R7 released after nack", d, 8'hFF);
    do_stop();

    // random read; index byte uses low bit only
    do_start();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'hFF, ack);       chk("R4 index ff ack", ack, 1);
    do_start();
    wbyte({DEV, 1'b1}, ack); chk("R9 reread ack", ack, 1);
    rbyte(d, 1'b0);          chk("R9 random read", d, mreg[1]);
    do_stop();
    mcnt = 0;

    // START in the middle of an index byte
    do_start();
    wbyte({DEV, 1'b0}, ack);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    do_start();
    wbyte({DEV, 1'b1}, ack); chk("R1 restart addr ack", ack, 1);
    rbyte(d, 1'b0);          chk("R1 counter kept", d, mreg[mcnt]);
    mcnt = (mcnt + 1) % 2;
    do_stop();

    // data sweep over both start indices
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, b;
      int s, r;
      a = 8'(i * 17) ^ 8'h5A;
      b = ~8'(i * 29);
      s = i % 2;
      r = (i + 1) % 2;
      do_start();
      wbyte({DEV, 1'b0}, ack);
      wbyte(8'(s), ack);
      wbyte(a, ack);
      wbyte(b, ack);         chk("R4 sweep ack", ack, 1);
      do_stop();
      mreg[s] = a; mreg[1-s] = b; mcnt = s;
      chk("R4 sweep reg0", regq[7:0], mreg[0]);
      chk("R4 sweep reg1", regq[15:8], mreg[1]);
      do_start();
      wbyte({DEV, 1'b0}, ack);
      wbyte(8'(r), ack);
      do_start();
      wbyte({DEV, 1'b1}, ack);
      rbyte(d, 1'b1);        chk("R9 sweep first", d, mreg[r]);
      rbyte(d, 1'b0);        chk("R5 sweep second", d, mreg[1-r]);
      do_stop();
      mcnt = r;
      do_start();
      wbyte({DEV, 1'b1}, ack);
      rbyte(d, 1'b0);        chk("R8 sweep current", d, mreg[mcnt]);
      do_stop();
      mcnt = (mcnt + 1) % 2;
    end

    // every foreign address is ignored
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != DEV) begin
        do_start();
        wbyte({7'(a), 1'b0}, ack); chk("R3 no addr ack", ack, 0);
        wbyte(8'h00, ack);         chk("R3 no data ack", ack, 0);
        wbyte(~8'(a), ack);
        do_stop();
      end
    end
    chk("R3 regs untouched", regq, {mreg[1], mreg[0]});
    do_start();
    wbyte({DEV, 1'b1}, ack);
    rbyte(d, 1'b0);          chk("R3 counter untouched", d, mreg[mcnt]);
    do_stop();

    chk("R10 no drive change with SCL high", r10_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule